// File: doc/BRIEF.md
# Sequential Serial-EEPROM Fetch Controller

This block turns single-byte fetch requests from a processor into commands for an I2C master engine. Program memory lives in one or more serial EEPROMs on the same bus. The upper bits of a fetch address select the chip, and the lower bits give the offset inside that chip. The block reads each byte from the EEPROM and returns it with a one-cycle valid strobe.

A serial EEPROM steps its own address pointer after every byte that is read and acknowledged. The controller keeps a copy of where that pointer should now be. When a request asks for exactly that address on the chip that is already open, the controller issues one acknowledged read and nothing else. When the program jumps, or when the next byte falls on another chip, the controller first closes the open stream. It then sends a full addressing phase before the read. The bus has no minimum clock rate, so the controller may wait any time between bytes and still keep its position.

The I2C engine sits behind a command/response port. The controller holds a command until the engine signals completion. The engine reports the byte it read and whether the transfer failed.

Top module: `seq_fetch_ctrl`

## Requirements
- R1: After reset, `fetch_rdy` is 1 and `cmd_valid` and `fetch_valid` are 0. No read stream is open, so the first fetch gets a full addressing phase with no close-out. `cmd_valid` is never 1 while `fetch_rdy` is 1.
- R2: A full addressing phase is issued in this order:
  1. START.
  2. WRITE of the device byte with the read bit cleared.
  3. WRITE of the high byte of the in-chip offset, zero-extended to 16 bits.
  4. WRITE of the low byte of that offset.
  5. START.
  6. WRITE of the device byte with the read bit set.
  7. READ_ACK.

  The device byte is {4'b1010, chip number zero-extended to 3 bits, read bit}.
- R3: A fetch whose address equals the expected next address, on the chip that is already open, issues a single READ_ACK and no other command.
- R4: A fetch that misses while a stream is open first issues READ_NACK (its byte is discarded), then STOP. The full addressing phase of R2 follows.
- R5: After the last byte of a chip, the next fetch misses and reloads the new chip at offset 0. The expected address wraps at the top of the address space to chip 0, which also misses.
- R6: `fetch_valid` is 1 for exactly one cycle for each fetch, the cycle after the final READ_ACK completes. `fetch_data` then equals the byte returned by that READ_ACK.
- R7: `cmd_op` and `cmd_wdata` hold steady while `cmd_valid` is 1 and `cmd_done` is 0. The engine may take any number of cycles. Any idle time between fetches does not lose the stream position.
- R8: When a command completes with `rsp_err` set, the open stream is closed. The next command is STOP, or START if the failing command was itself a STOP. A full addressing phase for the same fetch then follows, with no READ_NACK.
- R9: Command codes on `cmd_op` are:
  - 1 = START
  - 2 = WRITE (`cmd_wdata` is sent)
  - 3 = READ_ACK
  - 4 = READ_NACK
  - 5 = STOP

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch request, taken while `fetch_rdy` is 1 |
| fetch_addr | input | CHIP_W+OFF_W | Byte address: chip in the upper bits, offset in the lower bits |
| fetch_rdy | output | 1 | Controller idle and able to take a request |
| fetch_valid | output | 1 | One-cycle strobe marking `fetch_data` |
| fetch_data | output | 8 | Fetched byte |
| cmd_valid | output | 1 | A command is presented to the I2C engine |
| cmd_op | output | 3 | Command code (R9) |
| cmd_wdata | output | 8 | Byte to send for WRITE |
| cmd_done | input | 1 | Engine finished the presented command this cycle |
| rsp_data | input | 8 | Byte returned by a READ command, valid with `cmd_done` |
| rsp_err | input | 1 | Command failed, valid with `cmd_done` |

## Verification
The bench builds the block with CHIP_W=2 and OFF_W=9, giving four 512-byte chips. With chips this small, random sequential runs regularly reach chip crossings and the wrap at the top of the address space. A 9-bit offset also makes the high address byte take both 0 and 1, so the high-byte field is exercised and not always zero. The bench's engine model emulates each EEPROM's auto-incrementing pointer. Any wrongly skipped or repeated addressing phase therefore shows up as wrong fetched data, as well as a mismatched command list.

// File: rtl/fetch_ctrl_pkg.sv
package fetch_ctrl_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_START   = 3'd1,
    OP_WRITE   = 3'd2,
    OP_RD_ACK  = 3'd3,
    OP_RD_NACK = 3'd4,
    OP_STOP    = 3'd5
  } bus_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_NACK,
    S_STOP,
    S_START,
    S_DEVW,
    S_AHI,
    S_ALO,
    S_RSTART,
    S_DEVR,
    S_READ
  } seq_state_e;

  // Device select byte: fixed EEPROM type code, chip number, direction bit.
  function automatic logic [7:0] dev_byte(input logic [2:0] sel, input logic rd);
    return {4'b1010, sel, rd};
  endfunction

endpackage

// File: rtl/seq_tracker.sv
module seq_tracker #(
  parameter int CHIP_W = 3,
  parameter int OFF_W  = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CHIP_W+OFF_W-1:0]  probe_addr,
  input  logic                     deliver,
  input  logic [CHIP_W+OFF_W-1:0]  done_addr,
  input  logic                     drop,
  output logic                     open_o,
  output logic                     hit_o
);
  localparam int AW = CHIP_W + OFF_W;

  logic [AW-1:0]     shadow_q;
  logic [CHIP_W-1:0] chip_q;
  logic              open_q;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [CHIP_W-1:0] chip_of(input logic [AW-1:0] a);
    return a[AW-1:OFF_W];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      chip_q   <= '0;
      open_q   <= 1'b0;
    end else if (drop) begin
      shadow_q <= '0;
      chip_q   <= '0;
      open_q   <= 1'b0;
    end else if (deliver) begin
      shadow_q <= step_addr(done_addr);
      chip_q   <= chip_of(done_addr);
      open_q   <= 1'b1;
    end
  end

  assign open_o = open_q;
  assign hit_o  = open_q && (probe_addr == shadow_q) && (chip_of(probe_addr) == chip_q);

endmodule

// File: rtl/cmd_sequencer.sv
module cmd_sequencer
  import fetch_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       hit,
  input  logic       open_i,
  input  logic       cmd_done,
  input  logic       rsp_err,
  output seq_state_e state_o,
  output logic       deliver,
  output logic       drop
);
  seq_state_e state_q, state_d;
  logic       busy_done;

  assign busy_done = (state_q != S_IDLE) && cmd_done;
  assign deliver   = busy_done && !rsp_err && (state_q == S_READ);
  assign drop      = busy_done && (rsp_err || state_q == S_STOP);

  always_comb begin
    state_d = state_q;
    if (state_q == S_IDLE) begin
      if (take) state_d = hit ? S_READ : (open_i ? S_NACK : S_START);
    end else if (busy_done) begin
      if (state_q == S_STOP)  state_d = S_START;
      else if (rsp_err)       state_d = S_STOP;
      else begin
        case (state_q)
          S_NACK:   state_d = S_STOP;
          S_START:  state_d = S_DEVW;
          S_DEVW:   state_d = S_AHI;
          S_AHI:    state_d = S_ALO;
          S_ALO:    state_d = S_RSTART;
          S_RSTART: state_d = S_DEVR;
          S_DEVR:   state_d = S_READ;
          default:  state_d = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/cmd_formatter.sv
module cmd_formatter
  import fetch_ctrl_pkg::*;
#(
  parameter int CHIP_W = 3,
  parameter int OFF_W  = 13
) (
  input  seq_state_e               state,
  input  logic [CHIP_W+OFF_W-1:0]  addr,
  output logic                     cmd_valid,
  output logic [2:0]               cmd_op,
  output logic [7:0]               cmd_wdata
);
  localparam int AW = CHIP_W + OFF_W;

  logic [2:0]  sel3;
  logic [15:0] off16;
  bus_op_e     op;

  generate
    if (CHIP_W == 3) begin : g_sel_full
      assign sel3 = addr[AW-1:OFF_W];
    end else begin : g_sel_pad
      assign sel3 = {{(3-CHIP_W){1'b0}}, addr[AW-1:OFF_W]};
    end
    if (OFF_W == 16) begin : g_off_full
      assign off16 = addr[OFF_W-1:0];
    end else begin : g_off_pad
      assign off16 = {{(16-OFF_W){1'b0}}, addr[OFF_W-1:0]};
    end
  endgenerate

  always_comb begin
    op        = OP_NONE;
    cmd_wdata = 8'h00;
    case (state)
      S_NACK:   op = OP_RD_NACK;
      S_STOP:   op = OP_STOP;
      S_START:  op = OP_START;
      S_RSTART: op = OP_START;
      S_DEVW:   begin op = OP_WRITE; cmd_wdata = dev_byte(sel3, 1'b0); end
      S_AHI:    begin op = OP_WRITE; cmd_wdata = off16[15:8]; end
      S_ALO:    begin op = OP_WRITE; cmd_wdata = off16[7:0]; end
      S_DEVR:   begin op = OP_WRITE; cmd_wdata = dev_byte(sel3, 1'b1); end
      S_READ:   op = OP_RD_ACK;
      default:  op = OP_NONE;
    endcase
  end

  assign cmd_op    = op;
  assign cmd_valid = (state != S_IDLE);

endmodule

// File: rtl/seq_fetch_ctrl.sv
module seq_fetch_ctrl
  import fetch_ctrl_pkg::*;
#(
  parameter int CHIP_W = 3,
  parameter int OFF_W  = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fetch_req,
  input  logic [CHIP_W+OFF_W-1:0] fetch_addr,
  output logic                    fetch_rdy,
  output logic                    fetch_valid,
  output logic [7:0]              fetch_data,
  output logic                    cmd_valid,
  output logic [2:0]              cmd_op,
  output logic [7:0]              cmd_wdata,
  input  logic                    cmd_done,
  input  logic [7:0]              rsp_data,
  input  logic                    rsp_err
);
  localparam int AW = CHIP_W + OFF_W;

  seq_state_e    state;
  logic          take, hit, open_s, deliver, drop;
  logic [AW-1:0] lat_addr;

  // Named events for the bound checker
  logic evt_hit, evt_reopen;

  assign fetch_rdy  = (state == S_IDLE);
  assign take       = fetch_rdy && fetch_req;
  assign evt_hit    = take && hit;
  assign evt_reopen = take && !hit && open_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr    <= '0;
      fetch_valid <= 1'b0;
      fetch_data  <= 8'h00;
    end else begin
      if (take) lat_addr <= fetch_addr;
      fetch_valid <= deliver;
      if (deliver) fetch_data <= rsp_data;
    end
  end

  seq_tracker #(.CHIP_W(CHIP_W), .OFF_W(OFF_W)) u_track (
    .clk(clk), .rst_n(rst_n), .probe_addr(fetch_addr), .deliver(deliver),
    .done_addr(lat_addr), .drop(drop), .open_o(open_s), .hit_o(hit)
  );

  cmd_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .take(take), .hit(hit), .open_i(open_s),
    .cmd_done(cmd_done), .rsp_err(rsp_err), .state_o(state),
    .deliver(deliver), .drop(drop)
  );

  cmd_formatter #(.CHIP_W(CHIP_W), .OFF_W(OFF_W)) u_fmt (
    .state(state), .addr(lat_addr), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_wdata(cmd_wdata)
  );

endmodule

// File: rtl/fetch_ctrl_chk.sv
module fetch_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fetch_rdy,
  input logic       fetch_valid,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic [7:0] cmd_wdata,
  input logic       cmd_done,
  input logic       rsp_err,
  input logic       evt_hit,
  input logic       evt_reopen
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_rdy |-> !cmd_valid);

  assert_hit_one_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hit |=> (cmd_valid && cmd_op == 3'd3));

  assert_miss_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_reopen |=> (cmd_valid && cmd_op == 3'd4));

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> !fetch_valid);

  assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_wdata)));

  assert_err_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_done && rsp_err) |=> (cmd_valid && (cmd_op == 3'd5 || cmd_op == 3'd1)));

endmodule

bind seq_fetch_ctrl fetch_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_rdy(fetch_rdy), .fetch_valid(fetch_valid),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
  .cmd_done(cmd_done), .rsp_err(rsp_err), .evt_hit(evt_hit), .evt_reopen(evt_reopen)
);

// File: tb/seq_fetch_ctrl_tb.sv
module seq_fetch_ctrl_tb;
  localparam int CW = 2;
  localparam int OW = 9;
  localparam int AW = CW + OW;
  localparam int CB = 1 << OW;
  localparam int SPACE = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_req = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          fetch_rdy, fetch_valid, cmd_valid;
  logic [7:0]    fetch_data, cmd_wdata;
  logic [2:0]    cmd_op;
  logic          cmd_done = 1'b0;
  logic [7:0]    rsp_data = 8'h00;
  logic          rsp_err = 1'b0;

  always #2.5 clk = ~clk;

  seq_fetch_ctrl #(.CHIP_W(CW), .OFF_W(OW)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_rdy(fetch_rdy), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
    .cmd_done(cmd_done), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model of the controller's view
  bit b_open = 0;
  int b_shadow = 0, b_chip = 0;

  // command log and expected list
  int log_op[64], log_wd[64], log_n = 0;
  int exp_op[64], exp_wd[64], exp_n = 0;
  int inj_idx = -1;

  // EEPROM emulation
  int e_phase = 0, e_chip = 0, e_hi = 0, e_ptr = 0;

  function automatic logic [7:0] mem_b(input int chip, input int off);
    int v;
    v = off * 37 + chip * 101 + 5;
    return v[7:0];
  endfunction

  function automatic int dev_b(input int chip, input int rd);
    return 160 + chip * 2 + rd;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic push(input int op, input int wd);
    exp_op[exp_n] = op; exp_wd[exp_n] = wd; exp_n++;
  endtask

  task automatic push_reload(input int chip, input int off);
    push(1, 0); push(2, dev_b(chip, 0)); push(2, off / 256); push(2, off % 256);
    push(1, 0); push(2, dev_b(chip, 1)); push(3, 0);
  endtask

  // engine: execute one command on the emulated memory
  task automatic exec(input int op, input int wd, input bit err);
    rsp_err = err;
    if (!err) begin
      case (op)
        1: e_phase = 1;
        2: begin
          if (e_phase == 1) begin
            e_chip = (wd / 2) % 8;
            e_phase = (wd % 2 == 0) ? 2 : 0;
          end else if (e_phase == 2) begin
            e_hi = wd; e_phase = 3;
          end else if (e_phase == 3) begin
            e_ptr = (e_hi * 256 + wd) % CB; e_phase = 0;
          end
        end
        3, 4: begin
          rsp_data = mem_b(e_chip, e_ptr);
          e_ptr = (e_ptr + 1) % CB;
        end
        default: ;
      endcase
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cmd_done = 1'b0;
      rsp_err  = 1'b0;
      if (cmd_valid && rst_n) begin
        int op, wd, dly;
        op = int'(cmd_op); wd = int'(cmd_wdata);
        dly = $urandom_range(3, 0);
        repeat (dly) @(negedge clk);
        if (log_n < 64) begin log_op[log_n] = op; log_wd[log_n] = wd; end
        exec(op, wd, (log_n == inj_idx));
        log_n++;
        cmd_done = 1'b1;
      end
    end
  end

  task automatic do_fetch(input int a, input int err_at, input string tag);
    int chip, off, k;
    bit hit, same;
    chip = a / CB; off = a % CB;
    hit = b_open && (a == b_shadow) && (chip == b_chip);
    exp_n = 0;
    if (hit) push(3, 0);
    else begin
      if (b_open) begin push(4, 0); push(5, 0); end
      push_reload(chip, off);
    end
    if (err_at >= 0) begin
      exp_n = err_at + 1;
      if (exp_op[err_at] != 5) push(5, 0);
      push_reload(chip, off);
    end
    log_n = 0; inj_idx = err_at;
    while (!fetch_rdy) @(negedge clk);
    fetch_req = 1'b1; fetch_addr = AW'(a);
    @(negedge clk);
    fetch_req = 1'b0;
    while (!fetch_valid) @(negedge clk);
    chk(fetch_data == mem_b(chip, off), {tag, " R6 data"}, int'(fetch_data), int'(mem_b(chip, off)));
    same = (log_n == exp_n);
    k = -1;
    if (same) for (int i = 0; i < exp_n; i++) begin
      if (log_op[i] != exp_op[i] || (exp_op[i] == 2 && log_wd[i] != exp_wd[i])) begin
        if (k < 0) k = i;
        same = 0;
      end
    end
    if (k < 0) chk(same, {tag, " R9 command count"}, log_n, exp_n);
    else chk(same, {tag, " R9 command op/byte"}, log_op[k] * 256 + log_wd[k], exp_op[k] * 256 + exp_wd[k]);
    inj_idx = -1;
    @(negedge clk);
    chk(!fetch_valid, "R6 single-cycle strobe", int'(fetch_valid), 0);
    b_open = 1; b_shadow = (a + 1) % SPACE; b_chip = chip;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fetch_rdy && !cmd_valid && !fetch_valid, "R1 reset state",
        {fetch_rdy, cmd_valid, fetch_valid}, 3'b100);

    do_fetch(12'h0FE, -1, "R1 R2 first fetch");
    do_fetch(12'h0FF, -1, "R3 sequential");
    do_fetch(12'h100, -1, "R3 sequential high byte step");
    do_fetch(12'h050, -1, "R4 jump");
    repeat (500) @(negedge clk);
    do_fetch(12'h051, -1, "R7 after long pause");
    do_fetch(12'h1FF, -1, "R4 jump to chip end");
    do_fetch(12'h200, -1, "R5 chip crossing");
    do_fetch(12'h7FF, -1, "R4 jump to top");
    do_fetch(12'h000, -1, "R5 wrap to chip 0");
    do_fetch(12'h001, -1, "R3 sequential");
    do_fetch(12'h300, 4, "R8 error on high address byte");
    do_fetch(12'h301, -1, "R8 stream after recovery");
    do_fetch(12'h302, 0, "R8 error on streamed read");
    do_fetch(12'h123, 1, "R8 error on close stop");

    for (int n = 0; n < 300; n++) begin
      int a, g;
      if ($urandom_range(99, 0) < 75) a = b_shadow;
      else a = $urandom_range(SPACE - 1, 0);
      g = $urandom_range(6, 0);
      if ($urandom_range(49, 0) == 0) g = 120;
      repeat (g) @(negedge clk);
      do_fetch(a, -1, "R3 R4 R5 R7 random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule